// File: doc/BRIEF.md
# Memory-Mapped Configuration Window Decoder

This block sits between a processor-side load/store path and the configuration port of a PCI Express host. Software programs a window by giving a base address, a size and an enable bit. A read or write of 1, 2 or 4 bytes that lands inside the mapped window has the base subtracted from its address. The resulting offset is cut into a bus number, a combined device/function number and a register offset, and the access is sent to the downstream configuration port. Read data comes back to the requester. Accesses outside the window, accesses while nothing is mapped, and accesses with an unsupported length go to a built-in default responder. That responder returns all-ones and drops writes.

Every reprogramming first tears down the current mapping. The new mapping is applied only when the enable bit is set and the size is legal. A legal size is a power of two from 1 MiB to 256 MiB, so the size sets how many bus numbers can be reached. An illegal size with enable set is refused and reported on a one-cycle error output.

A single state machine sequences both jobs:
- Its states are IDLE, SIZECHK, MAP, FWD and RESP.
- IDLE goes to SIZECHK when programming is accepted. This move also unmaps the window.
- SIZECHK goes to MAP when enable is set and the size is legal. Otherwise it goes back to IDLE.
- MAP goes to IDLE and loads the new base and size.
- IDLE goes to FWD when a request hits with a legal length. IDLE goes to RESP for any other request.
- FWD goes to RESP on the downstream handshake.
- RESP goes to IDLE after its single response cycle.

Top module: `cfg_window_decoder`

## Requirements
- R1: Out of reset the window is unmapped, `prog_ready` and `req_ready` are high, and `cfg_valid`, `rsp_valid` and `prog_err` are low.
- R2: A request hits only while the window is mapped and base <= address < base + size. The decode offset is the address minus the base.
- R3: On a hit the downstream port carries the following fields of the offset:
  - `cfg_bus` = offset[27:20]
  - `cfg_devfn` = {offset[19:15] device, offset[14:12] function}
  - `cfg_reg` = offset[11:0]

  The port also carries the request's write flag, length and write data.
- R4: `cfg_bus` is masked to the bits the window size covers, so it is always below size / 2^20. A 1 MiB window reaches only bus 0.
- R5: `req_len` is a byte count. Only the values 1, 2 and 4 are forwarded. Any other value is answered by the default responder and never reaches the downstream port.
- R6: Every request that is not forwarded completes with `rsp_rdata` all-ones and causes no downstream request, which means writes are dropped.
- R7: A forwarded read returns the `cfg_rdata` value sampled at the downstream handshake on `rsp_rdata`. Every request gets exactly one `rsp_valid` pulse of one cycle.
- R8: `cfg_valid` stays high with stable fields until `cfg_ready`. No new request is accepted while one is outstanding.
- R9: Programming is accepted only in IDLE, and the accepting clock edge unmaps the window. If `prog_enable` is set and the size is legal, the new base and size take effect two edges later. If `prog_enable` is clear, the window stays unmapped and no error is raised.
- R10: A legal size is a power of two from 2^20 to 2^28. With `prog_enable` set, any other size raises `prog_err` for exactly the cycle after acceptance and leaves the window unmapped.
- R11: Programming takes priority over a request in IDLE: `req_ready` is low whenever `prog_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_valid | input | 1 | Window programming request |
| prog_ready | output | 1 | Programming can be accepted (IDLE) |
| prog_enable | input | 1 | Map the window after the teardown |
| prog_base | input | ADDR_W | New window base |
| prog_size | input | ADDR_W | New window size in bytes |
| prog_err | output | 1 | Illegal size refused (one-cycle pulse) |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Access request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | DATA_W | Read data for the completion |
| cfg_valid | output | 1 | Downstream configuration request |
| cfg_ready | input | 1 | Downstream accepts/completes the request |
| cfg_write | output | 1 | Downstream write flag |
| cfg_bus | output | 8 | Bus number |
| cfg_devfn | output | 8 | {device, function} |
| cfg_reg | output | 12 | Register offset |
| cfg_len | output | 3 | Length in bytes |
| cfg_wdata | output | DATA_W | Write data |
| cfg_rdata | input | DATA_W | Read data, valid with cfg_ready |

## Verification
The assertions take some behaviour of the neighbours for granted:
- The downstream side returns read data in the same cycle as `cfg_ready`.
- `prog_valid` and `req_valid` stay high until they are accepted.
- Addresses plus the window size never pass the top of the address space.

The stimulus honours all of this. It holds every request until the ready output rises. Its downstream model raises `cfg_ready` after zero to two idle cycles and drives data with it. It places window bases so that base + size stays inside 32 bits. Within those limits the addresses are random and land inside the window, just below it and just above it. Lengths include the illegal values 0 and 3, and the directed cases probe both window edges and illegal sizes.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int REG_W = 12;
    localparam int BUS_LSB = REG_W + FN_W + DEV_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SIZECHK,
        ST_MAP,
        ST_FWD,
        ST_RESP
    } win_state_e;

    function automatic logic len_legal(input logic [2:0] len);
        return (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    endfunction

endpackage

// File: rtl/cfgwin_window.sv
module cfgwin_window #(
    parameter int ADDR_W = 32,
    parameter int MIN_LG = 20,
    parameter int MAX_LG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unmap_i,
    input  logic              map_i,
    input  logic [ADDR_W-1:0] new_base_i,
    input  logic [ADDR_W-1:0] new_size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              size_ok_o,
    output logic              mapped_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] size_o,
    output logic [ADDR_W-1:0] offset_o
);
    localparam int NSZ = MAX_LG - MIN_LG + 1;

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] size_q;
    logic [NSZ-1:0]    size_match;

    for (genvar k = MIN_LG; k <= MAX_LG; k++) begin : g_size
        assign size_match[k-MIN_LG] = (new_size_i == (ADDR_W'(1) << k));
    end

    assign size_ok_o = |size_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '1;
            size_q <= '0;
        end else if (unmap_i) begin
            base_q <= '1;
            size_q <= '0;
        end else if (map_i) begin
            base_q <= new_base_i;
            size_q <= new_size_i;
        end
    end

    assign mapped_o = (base_q != '1);
    assign hit_o    = ({1'b0, addr_i} >= {1'b0, base_q}) &&
                      ({1'b0, addr_i} <  ({1'b0, base_q} + {1'b0, size_q}));
    assign offset_o = addr_i - base_q;
    assign size_o   = size_q;

endmodule

// File: rtl/cfgwin_split.sv
module cfgwin_split
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]    offset_i,
    input  logic [ADDR_W-1:0]    size_i,
    output logic [BUS_W-1:0]     bus_o,
    output logic [DEV_W+FN_W-1:0] devfn_o,
    output logic [REG_W-1:0]     reg_o
);
    logic [BUS_W-1:0] bus_mask;

    assign bus_mask = BUS_W'((size_i >> BUS_LSB) - ADDR_W'(1));
    assign bus_o    = BUS_W'(offset_i >> BUS_LSB) & bus_mask;
    assign devfn_o  = (DEV_W+FN_W)'(offset_i >> REG_W);
    assign reg_o    = REG_W'(offset_i);

endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int MIN_LG = 20,
    parameter int MAX_LG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_valid,
    output logic              prog_ready,
    input  logic              prog_enable,
    input  logic [ADDR_W-1:0] prog_base,
    input  logic [ADDR_W-1:0] prog_size,
    output logic              prog_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    output logic              cfg_write,
    output logic [7:0]        cfg_bus,
    output logic [7:0]        cfg_devfn,
    output logic [11:0]       cfg_reg,
    output logic [2:0]        cfg_len,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_rdata
);
    win_state_e state_q, state_d;

    logic [ADDR_W-1:0] pend_base_q, pend_size_q;
    logic              pend_en_q;
    logic              q_write;
    logic [2:0]        q_len;
    logic [DATA_W-1:0] q_wdata, q_rdata;
    logic [BUS_W-1:0]  q_bus;
    logic [7:0]        q_devfn;
    logic [REG_W-1:0]  q_reg;

    logic              win_unmap, win_map, win_size_ok, win_mapped, win_hit;
    logic [ADDR_W-1:0] win_size, win_offset;
    logic [BUS_W-1:0]  sp_bus;
    logic [7:0]        sp_devfn;
    logic [REG_W-1:0]  sp_reg;
    logic              prog_take, req_take, req_fwd;

    assign prog_take = (state_q == ST_IDLE) && prog_valid;
    assign req_take  = (state_q == ST_IDLE) && !prog_valid && req_valid;
    assign req_fwd   = win_mapped && win_hit && len_legal(req_len);
    assign win_unmap = prog_take;
    assign win_map   = (state_q == ST_MAP);

    cfgwin_window #(
        .ADDR_W (ADDR_W),
        .MIN_LG (MIN_LG),
        .MAX_LG (MAX_LG)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmap_i    (win_unmap),
        .map_i      (win_map),
        .new_base_i (pend_base_q),
        .new_size_i (pend_size_q),
        .addr_i     (req_addr),
        .size_ok_o  (win_size_ok),
        .mapped_o   (win_mapped),
        .hit_o      (win_hit),
        .size_o     (win_size),
        .offset_o   (win_offset)
    );

    cfgwin_split #(
        .ADDR_W (ADDR_W)
    ) u_split (
        .offset_i (win_offset),
        .size_i   (win_size),
        .bus_o    (sp_bus),
        .devfn_o  (sp_devfn),
        .reg_o    (sp_reg)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (prog_valid)      state_d = ST_SIZECHK;
                else if (req_valid)  state_d = req_fwd ? ST_FWD : ST_RESP;
            end
            ST_SIZECHK: state_d = (pend_en_q && win_size_ok) ? ST_MAP : ST_IDLE;
            ST_MAP:     state_d = ST_IDLE;
            ST_FWD:     state_d = cfg_ready ? ST_RESP : ST_FWD;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_base_q <= '0;
            pend_size_q <= '0;
            pend_en_q   <= 1'b0;
            q_write     <= 1'b0;
            q_len       <= '0;
            q_wdata     <= '0;
            q_rdata     <= '0;
            q_bus       <= '0;
            q_devfn     <= '0;
            q_reg       <= '0;
        end else begin
            state_q <= state_d;
            if (prog_take) begin
                pend_base_q <= prog_base;
                pend_size_q <= prog_size;
                pend_en_q   <= prog_enable;
            end
            if (req_take) begin
                q_write <= req_write;
                q_len   <= req_len;
                q_wdata <= req_wdata;
                q_bus   <= sp_bus;
                q_devfn <= sp_devfn;
                q_reg   <= sp_reg;
                if (!req_fwd) q_rdata <= '1;
            end
            if ((state_q == ST_FWD) && cfg_ready) q_rdata <= cfg_rdata;
        end
    end

    always_comb begin
        prog_ready = (state_q == ST_IDLE);
        req_ready  = (state_q == ST_IDLE) && !prog_valid;
        prog_err   = (state_q == ST_SIZECHK) && pend_en_q && !win_size_ok;
        cfg_valid  = (state_q == ST_FWD);
        rsp_valid  = (state_q == ST_RESP);
        rsp_rdata  = q_rdata;
        cfg_write  = q_write;
        cfg_bus    = q_bus;
        cfg_devfn  = q_devfn;
        cfg_reg    = q_reg;
        cfg_len    = q_len;
        cfg_wdata  = q_wdata;
    end

endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_valid,
    input logic              prog_ready,
    input logic              prog_err,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              cfg_valid,
    input logic              cfg_ready,
    input logic              cfg_write,
    input logic [7:0]        cfg_bus,
    input logic [7:0]        cfg_devfn,
    input logic [11:0]       cfg_reg,
    input logic [2:0]        cfg_len,
    input logic              win_mapped,
    input logic [ADDR_W-1:0] win_size
);
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_bus) && $stable(cfg_devfn)
                                       && $stable(cfg_reg) && $stable(cfg_len) && $stable(cfg_write)));

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (!req_ready && !prog_ready));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_len_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_len == 3'd1 || cfg_len == 3'd2 || cfg_len == 3'd4));

    assert_bus_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ((ADDR_W'(cfg_bus) << 20) < win_size));

    assert_unmap_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_valid && prog_ready) |=> !win_mapped);

    assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> (!win_mapped && prog_ready && !prog_err));

    assert_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |-> !req_ready);

endmodule

bind cfg_window_decoder cfgwin_checker #(.ADDR_W(ADDR_W)) u_cfgwin_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_valid (prog_valid),
    .prog_ready (prog_ready),
    .prog_err   (prog_err),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_write  (cfg_write),
    .cfg_bus    (cfg_bus),
    .cfg_devfn  (cfg_devfn),
    .cfg_reg    (cfg_reg),
    .cfg_len    (cfg_len),
    .win_mapped (win_mapped),
    .win_size   (win_size)
);

// File: tb/test_cfg_window_decoder.sv
module test_cfg_window_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_valid = 1'b0, prog_enable = 1'b0;
    logic [31:0] prog_base = '0, prog_size = '0;
    logic        prog_ready, prog_err;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_len = 3'd4;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        cfg_valid, cfg_write;
    logic        cfg_ready = 1'b0;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [11:0] cfg_reg;
    logic [2:0]  cfg_len;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    logic        m_mapped = 1'b0;
    logic [31:0] m_base = '1, m_size = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_window_decoder i_cfg_window_decoder (
        .clk(clk), .rst_n(rst_n),
        .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_enable(prog_enable),
        .prog_base(prog_base), .prog_size(prog_size), .prog_err(prog_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
        .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg),
        .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit size_legal(input logic [31:0] s);
        return (s != 0) && ((s & (s - 1)) == 0) && (s >= 32'h0010_0000) && (s <= 32'h1000_0000);
    endfunction

    function automatic bit len_ok(input logic [2:0] l);
        return (l == 3'd1) || (l == 3'd2) || (l == 3'd4);
    endfunction

    function automatic bit exp_hit(input logic [31:0] a, input logic [2:0] l);
        return m_mapped && len_ok(l) && (a >= m_base) &&
               ({1'b0, a} < ({1'b0, m_base} + {1'b0, m_size}));
    endfunction

    task automatic do_prog(input logic en, input logic [31:0] base, input logic [31:0] size);
        bit exp_err;
        exp_err = en && !size_legal(size);
        @(negedge clk);
        prog_valid = 1'b1; prog_enable = en; prog_base = base; prog_size = size;
        #1;
        chk(req_ready == 1'b0, "R11 req_ready with prog_valid", {31'b0, req_ready}, 32'd0);
        while (!prog_ready) @(negedge clk);
        @(negedge clk);
        prog_valid = 1'b0;
        chk(prog_err == exp_err, "R10 prog_err in check cycle", {31'b0, prog_err}, {31'b0, exp_err});
        @(negedge clk);
        chk(prog_err == 1'b0, "R10 prog_err one cycle", {31'b0, prog_err}, 32'd0);
        while (!prog_ready) @(negedge clk);
        m_mapped = en && size_legal(size);
        m_base   = m_mapped ? base : '1;
        m_size   = m_mapped ? size : '0;
    endtask

    task automatic do_req(input logic wr, input logic [31:0] addr, input logic [2:0] len, input logic [31:0] wd);
        bit          hit, seen, done;
        logic [31:0] off, rd, exp_bus;
        int          guard;
        hit = exp_hit(addr, len);
        off = addr - m_base;
        rd  = $urandom;
        exp_bus = {24'b0, off[27:20]} & ((m_size >> 20) - 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = len; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0; done = 0; guard = 0;
        while (!done && guard < 40) begin
            guard++;
            if (rsp_valid) begin
                done = 1;
                if (!wr) begin
                    if (hit) chk(rsp_rdata == rd, "R7 read data returned", rsp_rdata, rd);
                    else     chk(rsp_rdata == '1, "R6 default read all-ones", rsp_rdata, '1);
                end
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R7 single response pulse", {31'b0, rsp_valid}, 32'd0);
            end else if (cfg_valid && !seen) begin
                seen = 1;
                chk(hit, "R2 forwarded only on hit", {31'b0, cfg_valid}, {31'b0, hit});
                chk({24'b0, cfg_bus} == exp_bus, "R4 bus masked to window", {24'b0, cfg_bus}, exp_bus);
                chk(cfg_bus == off[27:20], "R3 bus field", {24'b0, cfg_bus}, {24'b0, off[27:20]});
                chk(cfg_devfn == {off[19:15], off[14:12]}, "R3 devfn field", {24'b0, cfg_devfn}, {24'b0, off[19:12]});
                chk(cfg_reg == off[11:0], "R3 register offset", {20'b0, cfg_reg}, {20'b0, off[11:0]});
                chk(cfg_write == wr && cfg_len == len, "R3 write flag and length",
                    {28'b0, cfg_write, cfg_len}, {28'b0, wr, len});
                if (wr) chk(cfg_wdata == wd, "R3 write data", cfg_wdata, wd);
                repeat ($urandom % 3) @(negedge clk);
                chk(cfg_valid == 1'b1, "R8 cfg_valid held", {31'b0, cfg_valid}, 32'd1);
                cfg_ready = 1'b1; cfg_rdata = rd;
                @(negedge clk);
                cfg_ready = 1'b0; cfg_rdata = '0;
            end else begin
                @(negedge clk);
            end
        end
        chk(done, "R7 response arrived", {31'b0, done}, 32'd1);
        if (!hit) chk(!seen, (len_ok(len) ? "R6 miss not forwarded" : "R5 bad length not forwarded"),
                      {31'b0, seen}, 32'd0);
        else      chk(seen, "R2 hit forwarded", {31'b0, seen}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] b, s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(prog_ready && req_ready, "R1 ready after reset", {30'b0, prog_ready, req_ready}, 32'd3);
        chk(!cfg_valid && !rsp_valid && !prog_err, "R1 outputs idle after reset",
            {29'b0, cfg_valid, rsp_valid, prog_err}, 32'd0);
        do_req(1'b0, 32'hE000_0000, 3'd4, 32'h0);   // R1 unmapped: default response

        // R4 1 MiB window reaches bus 0 only; R2 edges
        do_prog(1'b1, 32'hE000_0000, 32'h0010_0000);
        do_req(1'b0, 32'hE000_0000, 3'd4, 32'h0);
        do_req(1'b0, 32'hE00F_FFFC, 3'd4, 32'h0);
        do_req(1'b1, 32'hE00A_B123, 3'd1, 32'hA5A5_5A5A);
        do_req(1'b0, 32'hE010_0000, 3'd4, 32'h0);
        do_req(1'b0, 32'hDFFF_FFFF, 3'd2, 32'h0);
        do_req(1'b1, 32'hE010_0004, 3'd4, 32'h1234_5678);   // R6 write miss dropped
        // R5 illegal lengths inside the window
        do_req(1'b0, 32'hE000_0100, 3'd3, 32'h0);
        do_req(1'b1, 32'hE000_0100, 3'd0, 32'hFFFF_0000);

        // R10 illegal sizes refused, window left unmapped
        do_prog(1'b1, 32'hC000_0000, 32'h0030_0000);
        do_req(1'b0, 32'hC000_0000, 3'd4, 32'h0);
        do_req(1'b0, 32'hE000_0000, 3'd4, 32'h0);
        do_prog(1'b1, 32'hC000_0000, 32'h2000_0000);
        do_prog(1'b1, 32'hC000_0000, 32'h0008_0000);
        // R9 enable clear keeps window unmapped, no error
        do_prog(1'b1, 32'h8000_0000, 32'h1000_0000);
        do_req(1'b0, 32'h8FF0_8004, 3'd4, 32'h0);
        do_prog(1'b0, 32'h8000_0000, 32'h1000_0000);
        do_req(1'b0, 32'h8FF0_8004, 3'd4, 32'h0);
        // R9 remap moves the window
        do_prog(1'b1, 32'h4000_0000, 32'h0400_0000);
        do_prog(1'b1, 32'h5000_0000, 32'h0400_0000);
        do_req(1'b0, 32'h4000_1000, 3'd4, 32'h0);
        do_req(1'b0, 32'h53FF_F000, 3'd4, 32'h0);

        // random windows and requests
        for (int w = 0; w < 8; w++) begin
            int lg;
            lg = 20 + int'($urandom % 9);
            s  = 32'h1 << lg;
            b  = {4'($urandom % 14), 28'h0} + (((w % 2) == 1) ? ($urandom & 32'h000F_F000) : 32'h0);
            do_prog(1'b1, b, s);
            for (int k = 0; k < 40; k++) begin
                logic [31:0] a;
                logic [2:0]  l;
                int          kind;
                kind = int'($urandom % 8);
                if (kind < 5)       a = b + ($urandom % s);
                else if (kind == 5) a = b - 1 - ($urandom % 4096);
                else                a = b + s + ($urandom % 4096);
                case ($urandom % 8)
                    0, 1:    l = 3'd1;
                    2, 3:    l = 3'd2;
                    4, 5:    l = 3'd4;
                    6:       l = 3'd3;
                    default: l = 3'd4;
                endcase
                do_req(1'($urandom % 2), a, l, $urandom);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule